// File: doc/BRIEF.md
# SAR Converter Start and Sequencing Control

This block is the digital side of a 10-bit successive-approximation converter in a microcontroller. Software starts a conversion by writing any value to the low result register. An external trigger pin can also start conversions. A mode bit selects single or continuous operation, and an external-trigger bit enables starts from the pin. When both bits are set, conversions repeat while the pin is sampled low. After reset, the first start in that mode needs a falling edge on the pin.

Each conversion tests one trial bit per pulse of a step-enable input, beginning with the MSB. A comparator input decides whether each bit is kept. The current trial code is driven to the capacitor DAC. When a conversion completes, the block latches the result into two 8-bit data registers, clears the read-only busy flag and raises an interrupt request. Software clears the interrupt request. A 4-bit channel field is kept in the control register and driven to the input multiplexer.

Register map, selected by the 2-bit address: 0 is control, 1 is the low result, 2 is interrupt, 3 is the high result. The control byte holds the continuous-mode bit in bit 0, the external-trigger bit in bit 1, the channel in bits 5:2 and the busy flag in bit 6.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A write to address 1 starts a conversion, whatever data is written. The written value is discarded, and the low result register keeps its previous contents.
- R2: A conversion takes exactly 10 step-enable pulses. The first trial code is 0x200. Bits are tested from the MSB down. A bit is kept when the comparator input is 1, meaning the input is at or above the trial code.
- R3: On the clock edge that takes the 10th step, the high result register (address 3) is loaded with result[9:2], and the low result register (address 1) is loaded with {result[1:0], 6'b0}. Both registers keep their values at all other times.
- R4: The busy flag (output and control bit 6) becomes 1 on the edge after an accepted start and returns to 0 on the completing edge. Writing bit 6 of the control register has no effect.
- R5: The interrupt request is set on the completing edge. Writing 1 to bit 0 of address 2 clears it. If a set and a clear happen in the same cycle, the set wins. Reset clears it.
- R6: With the mode bit 0 and the external-trigger bit 0, each start runs one conversion and busy stays 0 afterwards.
- R7: With the mode bit 1 and the external-trigger bit 0, a new conversion is accepted on the second edge after each completion. This repeats until software clears the mode bit. A conversion already running when the mode bit is cleared still completes.
- R8: With the external-trigger bit 1 and the mode bit 0, the pin is captured only on cycles where the strobe input is 1. A single conversion starts only when a high sample is followed by a low sample. Busy rises two edges after the strobed low sample. A low level with no preceding high sample starts nothing.
- R9: With both bits 1, a low pin level starts nothing until a falling edge has started the first conversion since reset. After that, conversions repeat while the latest sample is low. When a high sample arrives, the running conversion finishes and no new one starts.
- R10: A start request that arrives while busy is ignored and is not queued.
- R11: The channel field written to control bits 5:2 reads back and drives the chan_sel_o output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| trig_pin_i | input | 1 | External trigger pin |
| trig_strobe_i | input | 1 | Once-per-machine-cycle sample strobe for the pin |
| step_en_i | input | 1 | Conversion clock enable, one SAR bit per pulse |
| cmp_ge_i | input | 1 | Comparator: input at or above trial code |
| dac_code_o | output | 10 | Current trial code to the capacitor DAC |
| busy_o | output | 1 | Conversion in progress |
| irq_o | output | 1 | Conversion-complete interrupt request |
| chan_sel_o | output | 4 | Analog channel select |

## Verification
A write to address 1 shows up as busy after one edge. The 10th step pulse loads both data registers, sets the interrupt request and clears busy on that same edge. A continuous restart shows busy one cycle after completion. A strobed low sample that forms a falling edge shows busy after two edges. The bench drives every input on a falling clock edge and samples results at a later falling edge, so each check falls exactly on the cycle counted above. Each check also confirms the busy level one cycle before, to show that no start occurred early or late.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned CHAN_W   = 4;
    localparam int unsigned ADC_RES  = 10;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_DLO  = 2'd1,
        REG_IRQ  = 2'd2,
        REG_DHI  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              ext;
        logic              cont;
    } ctrl_t;

    localparam int unsigned CTRL_W   = $bits(ctrl_t);
    localparam int unsigned BUSY_BIT = CTRL_W;

    function automatic logic [DATA_W-1:0] ctrl_rd(input ctrl_t c, input logic busy);
        logic [DATA_W-1:0] r;
        r = '0;
        r[CTRL_W-1:0] = c;
        r[BUSY_BIT]   = busy;
        return r;
    endfunction
endpackage

// File: rtl/adc_trig_sampler.sv
`timescale 1ns/1ps
module adc_trig_sampler (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic strobe_i,
    output logic fall_o,
    output logic low_o
);
    logic smp_q;
    logic valid_q;
    logic fall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q   <= 1'b1;
            valid_q <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            fall_q <= strobe_i & valid_q & smp_q & ~pin_i;
            if (strobe_i) begin
                smp_q   <= pin_i;
                valid_q <= 1'b1;
            end
        end
    end

    assign fall_o = fall_q;
    assign low_o  = valid_q & ~smp_q;

    assert_edge_low_R8: assert property (@(posedge clk) disable iff (rst)
        fall_o |-> low_o);
    assert_edge_needs_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> !fall_o);
endmodule

// File: rtl/adc_sar_core.sv
`timescale 1ns/1ps
module adc_sar_core #(
    parameter int unsigned RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             step_i,
    input  logic             cmp_ge_i,
    output logic             busy_o,
    output logic [RES_W-1:0] trial_o,
    output logic             finish_o,
    output logic [RES_W-1:0] result_o
);
    localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};

    logic             busy_q;
    logic [RES_W-1:0] mask_q;
    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] keep;

    assign keep     = cmp_ge_i ? mask_q : '0;
    assign finish_o = busy_q & step_i & mask_q[0];
    assign result_o = acc_q | keep;
    assign trial_o  = acc_q | mask_q;
    assign busy_o   = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            mask_q <= '0;
            acc_q  <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                mask_q <= MSB_MASK;
                acc_q  <= '0;
            end
        end else if (step_i) begin
            acc_q  <= acc_q | keep;
            mask_q <= mask_q >> 1;
            if (mask_q[0]) busy_q <= 1'b0;
        end
    end

    assert_single_trial_R2: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> ($countones(mask_q) == 1));
    assert_hold_without_step_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !step_i) |=> ($stable(acc_q) && $stable(mask_q) && busy_o));
    assert_busy_drops_R4: assert property (@(posedge clk) disable iff (rst)
        finish_o |=> !busy_o);
    assert_start_raises_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && trial_o == MSB_MASK));
    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !step_i) |=> $stable(mask_q));
endmodule

// File: rtl/adc_start_ctrl.sv
`timescale 1ns/1ps
module adc_start_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic sw_start_i,
    input  logic cont_i,
    input  logic ext_i,
    input  logic fall_i,
    input  logic low_i,
    input  logic finish_i,
    input  logic busy_i,
    output logic start_o
);
    logic done_once_q;
    logic done_q;
    logic start_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_once_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= finish_i;
            if (finish_i) done_once_q <= 1'b1;
        end
    end

    always_comb begin
        start_req = sw_start_i;
        if (ext_i && fall_i)                        start_req = 1'b1;
        if (ext_i && cont_i && low_i && done_once_q) start_req = 1'b1;
        if (!ext_i && cont_i && done_q)             start_req = 1'b1;
    end

    assign start_o = start_req & ~busy_i;

    assert_auto_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (done_q && cont_i && !ext_i) |-> start_o);
    assert_first_needs_edge_R9: assert property (@(posedge clk) disable iff (rst)
        (!done_once_q && !sw_start_i && !fall_i) |-> !start_o);
    assert_single_no_level_R8: assert property (@(posedge clk) disable iff (rst)
        (!cont_i && !sw_start_i && !fall_i) |-> !start_o);
endmodule

// File: rtl/adc_reg_bank.sv
`timescale 1ns/1ps
module adc_reg_bank
    import adc_seq_pkg::*;
#(
    parameter int unsigned RES_W = ADC_RES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic [DATA_W-1:0]     rd_data_o,
    input  logic                  busy_i,
    input  logic                  finish_i,
    input  logic [RES_W-1:0]      result_i,
    output ctrl_t                 ctrl_o,
    output logic                  irq_o,
    output logic                  sw_start_o
);
    localparam int unsigned LO_BITS = RES_W - DATA_W;
    localparam int unsigned PAD_W   = DATA_W - LO_BITS;

    ctrl_t             ctrl_q;
    logic              irq_q;
    logic [DATA_W-1:0] dhi_q;
    logic [DATA_W-1:0] dlo_q;
    reg_addr_e         waddr;
    logic              wr_unused_bits;

    assign waddr          = reg_addr_e'(wr_addr_i);
    assign wr_unused_bits = ^wr_data_i[DATA_W-1:CTRL_W];
    assign sw_start_o     = wr_en_i && (waddr == REG_DLO);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            irq_q  <= 1'b0;
            dhi_q  <= '0;
            dlo_q  <= '0;
        end else begin
            if (wr_en_i && waddr == REG_CTRL)
                ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
            if (finish_i) begin
                irq_q <= 1'b1;
                dhi_q <= result_i[RES_W-1 -: DATA_W];
                dlo_q <= {result_i[LO_BITS-1:0], {PAD_W{1'b0}}};
            end else if (wr_en_i && waddr == REG_IRQ && wr_data_i[0]) begin
                irq_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (reg_addr_e'(rd_addr_i))
            REG_CTRL: rd_data_o = ctrl_rd(ctrl_q, busy_i);
            REG_DLO:  rd_data_o = dlo_q;
            REG_IRQ:  rd_data_o = {{(DATA_W-1){1'b0}}, irq_q};
            default:  rd_data_o = dhi_q;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign irq_o  = irq_q;

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !finish_i |=> ($stable(dhi_q) && $stable(dlo_q)));
    assert_irq_on_done_R5: assert property (@(posedge clk) disable iff (rst)
        finish_i |=> irq_o);
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned RES_W = ADC_RES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [7:0]        rd_data_o,
    input  logic              trig_pin_i,
    input  logic              trig_strobe_i,
    input  logic              step_en_i,
    input  logic              cmp_ge_i,
    output logic [RES_W-1:0]  dac_code_o,
    output logic              busy_o,
    output logic              irq_o,
    output logic [3:0]        chan_sel_o
);
    ctrl_t            ctrl;
    logic             sw_start;
    logic             fall_evt;
    logic             pin_low;
    logic             start;
    logic             busy;
    logic             finish;
    logic [RES_W-1:0] result;

    adc_reg_bank #(.RES_W(RES_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .busy_i     (busy),
        .finish_i   (finish),
        .result_i   (result),
        .ctrl_o     (ctrl),
        .irq_o      (irq_o),
        .sw_start_o (sw_start)
    );

    adc_trig_sampler u_trig (
        .clk      (clk),
        .rst      (rst),
        .pin_i    (trig_pin_i),
        .strobe_i (trig_strobe_i),
        .fall_o   (fall_evt),
        .low_o    (pin_low)
    );

    adc_start_ctrl u_start (
        .clk        (clk),
        .rst        (rst),
        .sw_start_i (sw_start),
        .cont_i     (ctrl.cont),
        .ext_i      (ctrl.ext),
        .fall_i     (fall_evt),
        .low_i      (pin_low),
        .finish_i   (finish),
        .busy_i     (busy),
        .start_o    (start)
    );

    adc_sar_core #(.RES_W(RES_W)) u_sar (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .step_i   (step_en_i),
        .cmp_ge_i (cmp_ge_i),
        .busy_o   (busy),
        .trial_o  (dac_code_o),
        .finish_o (finish),
        .result_o (result)
    );

    assign busy_o     = busy;
    assign chan_sel_o = ctrl.chan;

    assert_stop_on_high_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.ext && ctrl.cont && !pin_low && !fall_evt && !sw_start && !busy) |=> !busy);
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       trig_pin = 1'b1;
    logic       trig_strobe = 1'b0;
    logic       step_en = 1'b0;
    logic       cmp_ge;
    logic [9:0] dac_code;
    logic       busy;
    logic       irq;
    logic [3:0] chan_sel;
    logic [9:0] ain = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign cmp_ge = (ain >= dac_code);

    adc_seq_ctrl dut_i (
        .clk(clk), .rst(rst),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .trig_pin_i(trig_pin), .trig_strobe_i(trig_strobe),
        .step_en_i(step_en), .cmp_ge_i(cmp_ge),
        .dac_code_o(dac_code), .busy_o(busy), .irq_o(irq), .chan_sel_o(chan_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); step_en = 1'b1;
            @(negedge clk); step_en = 1'b0;
        end
    endtask

    task automatic pin_sample(input logic v);
        @(negedge clk);
        trig_pin = v; trig_strobe = 1'b1;
        @(negedge clk);
        trig_strobe = 1'b0;
    endtask

    task automatic idle_busy(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, busy, 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_result(input string req, input logic [9:0] v);
        logic [7:0] d;
        rd(2'd3, d); chk(req, d, v[9:2]);
        rd(2'd1, d); chk(req, d, {v[1:0], 6'b0});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R4 reset busy", busy, 0);
        chk("R5 reset irq", irq, 0);
        rd(2'd0, d); chk("R4 reset ctrl", d, 0);
        check_result("R3 reset data", 10'h000);
    endtask

    task automatic t_chan();
        logic [7:0] d;
        wr(2'd0, 8'h2C);
        rd(2'd0, d); chk("R11 ctrl readback", d, 8'h2C);
        chk("R11 chan_sel", chan_sel, 4'hB);
    endtask

    task automatic t_single_sw();
        logic [7:0] d;
        ain = 10'h2A5;
        wr(2'd1, 8'h5A);
        chk("R1 busy after write", busy, 1);
        chk("R2 first trial", dac_code, 10'h200);
        rd(2'd1, d); chk("R1 data not written", d, 0);
        rd(2'd0, d); chk("R4 busy bit read", d[6], 1);
        steps(9);
        chk("R2 busy after 9 steps", busy, 1);
        chk("R5 no irq yet", irq, 0);
        steps(1);
        chk("R4 busy clears", busy, 0);
        chk("R5 irq set", irq, 1);
        check_result("R3 result 0x2A5", 10'h2A5);
        idle_busy("R6 no restart", 3);
    endtask

    task automatic t_irq_clear();
        wr(2'd2, 8'h00);
        chk("R5 write 0 keeps irq", irq, 1);
        wr(2'd2, 8'h01);
        chk("R5 irq cleared", irq, 0);
    endtask

    task automatic t_busy_ro();
        logic [7:0] d;
        wr(2'd0, 8'h6C);
        chk("R4 busy write ignored", busy, 0);
        rd(2'd0, d); chk("R4 ctrl readback", d, 8'h2C);
        idle_busy("R4 no start from busy write", 2);
    endtask

    task automatic t_busy_ignore();
        ain = 10'h3FF;
        wr(2'd1, 8'h00);
        steps(4);
        wr(2'd1, 8'hFF);
        chk("R10 still busy", busy, 1);
        steps(6);
        chk("R10 ten steps only", busy, 0);
        check_result("R2 full scale", 10'h3FF);
        idle_busy("R10 not queued", 3);
        wr(2'd2, 8'h01);
    endtask

    task automatic t_cont_int();
        ain = 10'h000;
        wr(2'd0, 8'h2D);
        wr(2'd1, 8'h00);
        steps(10);
        chk("R7 busy clears", busy, 0);
        check_result("R2 zero scale", 10'h000);
        @(negedge clk);
        chk("R7 restarted", busy, 1);
        ain = 10'h155;
        steps(5);
        wr(2'd0, 8'h2C);
        steps(5);
        chk("R7 finishes", busy, 0);
        check_result("R3 result 0x155", 10'h155);
        idle_busy("R7 stops after clear", 3);
        wr(2'd2, 8'h01);
    endtask

    task automatic t_ext_single();
        wr(2'd0, 8'h02);
        ain = 10'h0F0;
        pin_sample(1'b0);
        idle_busy("R8 low without high", 2);
        pin_sample(1'b1);
        pin_sample(1'b1);
        idle_busy("R8 high level", 2);
        pin_sample(1'b0);
        chk("R8 one edge pending", busy, 0);
        @(negedge clk);
        chk("R8 edge start", busy, 1);
        steps(10);
        chk("R8 done", busy, 0);
        check_result("R8 result", 10'h0F0);
        pin_sample(1'b0);
        idle_busy("R8 level low single", 3);
        wr(2'd2, 8'h01);
    endtask

    task automatic t_ext_cont();
        do_reset();
        chk("R5 irq after reset", irq, 0);
        wr(2'd0, 8'h03);
        pin_sample(1'b0);
        idle_busy("R9 needs edge first", 3);
        pin_sample(1'b1);
        pin_sample(1'b0);
        @(negedge clk);
        chk("R9 edge start", busy, 1);
        ain = 10'h201;
        steps(10);
        chk("R9 first done", busy, 0);
        check_result("R9 result", 10'h201);
        @(negedge clk);
        chk("R9 level restart", busy, 1);
        steps(3);
        pin_sample(1'b1);
        chk("R9 running after high", busy, 1);
        steps(7);
        chk("R9 last finishes", busy, 0);
        idle_busy("R9 stopped", 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_chan();
        t_single_sw();
        t_irq_clear();
        t_busy_ro();
        t_busy_ignore();
        t_cont_int();
        t_ext_single();
        t_ext_cont();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule